// File: doc/BRIEF.md
# Eight-Bin Recursive DFT Engine

This block measures the spectrum of an incoming sample stream at eight fixed frequency bins, one per telephone keypad tone, without computing a full transform. Each bin holds a pair of state words that a second-order recursion updates once per accepted sample. After a frame of 256 samples, the block turns each bin's final two state words into a real and an imaginary part, raises a one-cycle done pulse, and clears its state so the next frame starts from zero.

All arithmetic passes through one signed multiplier that is shared in time. For each sample the engine spends eight consecutive cycles, one per bin. At frame end it spends sixteen cycles, two per bin, to form the outputs. The sample source must space its samples at least eight cycles apart. A magnitude estimator or digit decoder placed downstream reads the sixteen results while they are held on the output ports.

Top module: `goertzel_engine`

## Requirements
- R1: The eight bins use, in port order 0 to 7, the indices k = 22, 25, 27, 30, 39, 43, 47, 52 of a 256-point frame. Bin i uses the coefficients C = round(16384·cos(2πk/256)) and S = round(16384·sin(2πk/256)), rounded half away from zero.
- R2: For every accepted sample x, each bin updates its state as v = x + floor(C·s1 / 8192) − s2, then s2 ← s1 and s1 ← sat(v). The cosine term is doubled by the shift, not by a second coefficient.
- R3: Every value written to a state register or to a result is saturated to the range [−8388608, 8388607].
- R4: After the 256th sample of a frame, the real result of each bin is sat(s1 − floor(C·s2 / 16384)) and the imaginary result is sat(floor(S·s2 / 16384)).
- R5: `done` is high for exactly one cycle. It rises in the cycle that follows the 23rd rising edge after the edge that accepted the 256th sample.
- R6: A sample is accepted on a rising edge where `in_valid` is high and the engine is idle. The engine stays busy for the next 7 edges after each acceptance, and for the next 23 edges after the 256th acceptance. `in_valid` during busy edges is ignored.
- R7: When a frame completes, all state and the sample count return to zero, so the next frame does not depend on earlier frames.
- R8: While `rst` is high, `done` is low and every result is zero.
- R9: Bin i occupies bits [24·i+23 : 24·i] of `res_re` and of `res_im`, as two's complement. The results hold from one done pulse to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Signed input sample |
| done | output | 1 | One-cycle pulse when a frame's results are ready |
| res_re | output | 192 | Real results of the eight bins, packed |
| res_im | output | 192 | Imaginary results of the eight bins, packed |

## Verification
Each sample occupies exactly 8 edges: it is accepted on one edge, and the remaining seven bins update on the following seven. The done pulse comes 23 edges after the last acceptance. The bench drives every input on the falling edge and counts the rising edges from each acceptance. It tests done just before and just after the 23rd edge, and reads the results in the half-cycle where done is high. In the frames that inject garbage, the strobe stays high during every busy edge, so a sample accepted at the wrong moment corrupts the bench's arithmetic prediction.

// File: rtl/goertzel_pkg.sv
package goertzel_pkg;

    localparam int NUM_BINS  = 8;
    localparam int FRAME_LEN = 256;
    localparam int DATA_W    = 16;
    localparam int STATE_W   = 24;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 14;

    localparam int BIN_W  = $clog2(NUM_BINS);
    localparam int STEP_W = BIN_W + 1;
    localparam int CNT_W  = $clog2(FRAME_LEN);
    localparam int PROD_W = COEF_W + STATE_W;
    localparam int ACC_W  = PROD_W + 2;

    localparam real PI = 3.14159265358979323846;

    typedef logic signed [STATE_W-1:0] state_t;
    typedef logic signed [COEF_W-1:0]  coef_t;
    typedef logic signed [ACC_W-1:0]   acc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } eng_state_e;

    typedef struct packed {
        coef_t cos_q;
        coef_t sin_q;
    } coef_pair_t;

    localparam acc_t SAT_HI = {{(ACC_W-STATE_W+1){1'b0}}, {(STATE_W-1){1'b1}}};
    localparam acc_t SAT_LO = {{(ACC_W-STATE_W+1){1'b1}}, {(STATE_W-1){1'b0}}};

    // Frequency index of each tone bin within the frame.
    function automatic int bin_index(int b);
        case (b)
            0:       return 22;
            1:       return 25;
            2:       return 27;
            3:       return 30;
            4:       return 39;
            5:       return 43;
            6:       return 47;
            default: return 52;
        endcase
    endfunction

    function automatic coef_t round_q(real r);
        real scaled;
        scaled = r * real'(1 << COEF_FRAC);
        return coef_t'($rtoi(scaled + ((scaled >= 0.0) ? 0.5 : -0.5)));
    endfunction

    function automatic coef_t cos_q(int k);
        return round_q($cos(2.0 * PI * real'(k) / real'(FRAME_LEN)));
    endfunction

    function automatic coef_t sin_q(int k);
        return round_q($sin(2.0 * PI * real'(k) / real'(FRAME_LEN)));
    endfunction

    function automatic state_t sat_state(acc_t v);
        if (v > SAT_HI) return state_t'(SAT_HI[STATE_W-1:0]);
        if (v < SAT_LO) return state_t'(SAT_LO[STATE_W-1:0]);
        return state_t'(v[STATE_W-1:0]);
    endfunction

endpackage

// File: rtl/goertzel_coef_rom.sv
module goertzel_coef_rom
    import goertzel_pkg::*;
(
    input  logic [BIN_W-1:0] bin_sel,
    output coef_pair_t       coef
);

    coef_pair_t table_w [NUM_BINS];

    for (genvar g = 0; g < NUM_BINS; g++) begin : g_tab
        localparam coef_t C_VAL = cos_q(bin_index(g));
        localparam coef_t S_VAL = sin_q(bin_index(g));
        assign table_w[g] = '{cos_q: C_VAL, sin_q: S_VAL};
    end

    assign coef = table_w[bin_sel];

endmodule

// File: rtl/goertzel_mul.sv
module goertzel_mul
    import goertzel_pkg::*;
(
    input  coef_t                    mul_a,
    input  state_t                   mul_b,
    output logic signed [PROD_W-1:0] mul_p
);

    assign mul_p = PROD_W'(mul_a) * PROD_W'(mul_b);

endmodule

// File: rtl/goertzel_state_bank.sv
module goertzel_state_bank
    import goertzel_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic [NUM_BINS-1:0] we,
    input  state_t              new_val,
    output state_t              s1_q [NUM_BINS],
    output state_t              s2_q [NUM_BINS]
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < NUM_BINS; i++) begin
                s1_q[i] <= '0;
                s2_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_BINS; i++) begin
                if (we[i]) begin
                    s2_q[i] <= s1_q[i];
                    s1_q[i] <= new_val;
                end
            end
        end
    end

    // The shared datapath can serve only one bin per cycle.
    assert_one_writer_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we));

    for (genvar g = 0; g < NUM_BINS; g++) begin : g_chk
        assert_state_cleared_R7: assert property (@(posedge clk) disable iff (rst)
            clear |=> (s1_q[g] == '0 && s2_q[g] == '0));
    end

endmodule

// File: rtl/goertzel_engine.sv
module goertzel_engine
    import goertzel_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic signed [DATA_W-1:0]    in_sample,
    output logic                        done,
    output logic [NUM_BINS*STATE_W-1:0] res_re,
    output logic [NUM_BINS*STATE_W-1:0] res_im
);

    localparam logic [BIN_W-1:0]  LAST_BIN  = BIN_W'(NUM_BINS - 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(2 * NUM_BINS - 1);
    localparam logic [CNT_W-1:0]  LAST_SMP  = CNT_W'(FRAME_LEN - 1);

    eng_state_e                st;
    logic [BIN_W-1:0]          bin_q;
    logic [STEP_W-1:0]         step_q;
    logic [CNT_W-1:0]          cnt_q;
    logic signed [DATA_W-1:0]  x_q;
    logic                      done_q;
    state_t                    re_q [NUM_BINS];
    state_t                    im_q [NUM_BINS];

    state_t                    s1_w [NUM_BINS];
    state_t                    s2_w [NUM_BINS];

    logic                      accept;
    logic                      fin_imag;
    logic                      frame_end;
    logic [BIN_W-1:0]          cur_bin;
    logic signed [DATA_W-1:0]  x_cur;
    coef_pair_t                coef;
    coef_t                     mul_a;
    state_t                    mul_b;
    logic signed [PROD_W-1:0]  prod;
    acc_t                      prod_ext;
    acc_t                      rec_sum;
    acc_t                      fin_re;
    acc_t                      fin_im;
    logic [NUM_BINS-1:0]       we;

    assign accept    = (st == ST_IDLE) && in_valid;
    assign fin_imag  = (st == ST_FIN) && step_q[0];
    assign frame_end = (st == ST_FIN) && (step_q == LAST_STEP);

    // The first bin is updated on the accepting edge itself, so one sample occupies eight edges.
    always_comb begin
        case (st)
            ST_FIN:  cur_bin = step_q[STEP_W-1:1];
            ST_RUN:  cur_bin = bin_q;
            default: cur_bin = '0;
        endcase
    end

    assign x_cur = accept ? in_sample : x_q;

    goertzel_coef_rom u_rom (
        .bin_sel (cur_bin),
        .coef    (coef)
    );

    assign mul_a = fin_imag ? coef.sin_q : coef.cos_q;
    assign mul_b = (st == ST_FIN) ? s2_w[cur_bin] : s1_w[cur_bin];

    goertzel_mul u_mul (
        .mul_a (mul_a),
        .mul_b (mul_b),
        .mul_p (prod)
    );

    assign prod_ext = ACC_W'(prod);
    assign rec_sum  = ACC_W'(x_cur) + (prod_ext >>> (COEF_FRAC - 1)) - ACC_W'(s2_w[cur_bin]);
    assign fin_re   = ACC_W'(s1_w[cur_bin]) - (prod_ext >>> COEF_FRAC);
    assign fin_im   = prod_ext >>> COEF_FRAC;

    assign we = (accept || st == ST_RUN) ? (NUM_BINS'(1) << cur_bin) : '0;

    goertzel_state_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .clear   (frame_end),
        .we      (we),
        .new_val (sat_state(rec_sum)),
        .s1_q    (s1_w),
        .s2_q    (s2_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            bin_q  <= '0;
            step_q <= '0;
            cnt_q  <= '0;
            x_q    <= '0;
            done_q <= 1'b0;
            for (int i = 0; i < NUM_BINS; i++) begin
                re_q[i] <= '0;
                im_q[i] <= '0;
            end
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (in_valid) begin
                        x_q   <= in_sample;
                        bin_q <= BIN_W'(1);
                        st    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (bin_q == LAST_BIN) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (cnt_q == LAST_SMP) begin
                            step_q <= '0;
                            st     <= ST_FIN;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else begin
                        bin_q <= bin_q + BIN_W'(1);
                    end
                end
                ST_FIN: begin
                    if (fin_imag) im_q[cur_bin] <= sat_state(fin_im);
                    else          re_q[cur_bin] <= sat_state(fin_re);
                    step_q <= step_q + STEP_W'(1);
                    if (frame_end) begin
                        cnt_q  <= '0;
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_BINS; g++) begin : g_out
        assign res_re[g*STATE_W +: STATE_W] = re_q[g];
        assign res_im[g*STATE_W +: STATE_W] = im_q[g];
    end

    assign done = done_q;

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    assert_done_after_fin_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(st) == ST_FIN);

    assert_bin_walk_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && bin_q != LAST_BIN) |=> (st == ST_RUN && bin_q == $past(bin_q) + BIN_W'(1)));

    assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> $stable(x_q));

endmodule

// File: tb/goertzel_engine_tb_top.sv
module goertzel_engine_tb_top;

    localparam int NB = 8;
    localparam int FL = 256;
    localparam int SW = 24;
    localparam longint HI = 64'sd8388607;
    localparam longint LO = -64'sd8388608;
    localparam real TB_PI = 3.14159265358979323846;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 in_valid;
    logic signed [15:0]   in_sample;
    logic                 done;
    logic [NB*SW-1:0]     res_re;
    logic [NB*SW-1:0]     res_im;

    int          checks = 0;
    int          errs   = 0;
    int          xs [FL];
    longint      exp_re [NB];
    longint      exp_im [NB];
    int          sat_hits;
    logic [31:0] lcg = 32'h1234_5678;
    int          ks [NB] = '{22, 25, 27, 30, 39, 43, 47, 52};

    always #5 clk = ~clk;

    goertzel_engine dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .done      (done),
        .res_re    (res_re),
        .res_im    (res_im)
    );

    function automatic longint q14(real r);
        real t;
        t = r * 16384.0;
        return longint'($rtoi(t + ((t >= 0.0) ? 0.5 : -0.5)));
    endfunction

    function automatic int next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return int'($signed(lcg[31:16]));
    endfunction

    task automatic check(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic sat_val(input longint v, output longint r);
        if (v > HI) begin r = HI; sat_hits++; end
        else if (v < LO) begin r = LO; sat_hits++; end
        else r = v;
    endtask

    // Arithmetic prediction of all sixteen results from the requirement formulas.
    task automatic model();
        sat_hits = 0;
        for (int b = 0; b < NB; b++) begin
            longint c, sn, s1, s2, v, r;
            c  = q14($cos(2.0 * TB_PI * real'(ks[b]) / real'(FL)));
            sn = q14($sin(2.0 * TB_PI * real'(ks[b]) / real'(FL)));
            s1 = 0;
            s2 = 0;
            for (int n = 0; n < FL; n++) begin
                v = longint'(xs[n]) + ((c * s1) >>> 13) - s2;
                sat_val(v, r);
                s2 = s1;
                s1 = r;
            end
            sat_val(s1 - ((c * s2) >>> 14), exp_re[b]);
            sat_val((sn * s2) >>> 14, exp_im[b]);
        end
    endtask

    task automatic check_results(input string name);
        for (int b = 0; b < NB; b++) begin
            check($sformatf("%s R1/R2/R4/R9 bin%0d real", name, b),
                  longint'($signed(res_re[b*SW +: SW])), exp_re[b]);
            check($sformatf("%s R1/R2/R4/R9 bin%0d imag", name, b),
                  longint'($signed(res_im[b*SW +: SW])), exp_im[b]);
        end
    endtask

    // Drives one frame at the highest rate. With junk set, the strobe stays high on every busy edge (R6).
    task automatic send_frame(input bit junk, input string name);
        for (int n = 0; n < FL; n++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_sample = 16'(xs[n]);
            @(posedge clk);
            for (int j = 1; j < 8; j++) begin
                @(negedge clk);
                in_valid  = junk;
                in_sample = junk ? 16'(next_rand()) : '0;
                @(posedge clk);
            end
        end
        for (int j = 8; j < 24; j++) begin
            @(negedge clk);
            if (j == 23) check({name, " R5 done low before edge 23"}, longint'(done), 0);
            in_valid  = junk;
            in_sample = junk ? 16'(next_rand()) : '0;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid  = 1'b0;
        in_sample = '0;
        check({name, " R5 done high after edge 23"}, longint'(done), 1);
        check_results(name);
        @(posedge clk);
        @(negedge clk);
        check({name, " R5 done lasts one cycle"}, longint'(done), 0);
        check_results({name, " held"});
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_sample = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R8 done in reset", longint'(done), 0);
        check("R8 real results in reset", longint'(res_re != '0), 0);
        check("R8 imag results in reset", longint'(res_im != '0), 0);
        rst = 1'b0;

        // Frame 1: a tone pair on bins 0 and 4.
        for (int n = 0; n < FL; n++)
            xs[n] = $rtoi(8000.0 * $cos(2.0 * TB_PI * 22.0 * real'(n) / 256.0)
                        + 8000.0 * $cos(2.0 * TB_PI * 39.0 * real'(n) / 256.0));
        model();
        send_frame(1'b0, "tone pair");

        // Frame 2: full-range pseudo-random data with garbage on busy edges (R6).
        for (int n = 0; n < FL; n++) xs[n] = next_rand();
        model();
        send_frame(1'b1, "random R6");

        // Frame 3: a full-scale square wave on bin 0 drives the state to saturation (R3).
        for (int n = 0; n < FL; n++)
            xs[n] = ($sin(2.0 * TB_PI * 22.0 * real'(n) / 256.0) >= 0.0) ? 32767 : -32768;
        model();
        check("R3 square stimulus reaches saturation", longint'(sat_hits > 0), 1);
        send_frame(1'b0, "square R3");

        // Frame 4: silence after a saturated frame must give zero (R7).
        for (int n = 0; n < FL; n++) xs[n] = 0;
        model();
        send_frame(1'b1, "silence R7");

        // Frame 5: a single impulse excites every bin equally.
        for (int n = 0; n < FL; n++) xs[n] = (n == 0) ? 32767 : 0;
        model();
        send_frame(1'b1, "impulse R7");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule